// File: doc/BRIEF.md
# Line-Locked Pixel Clock Loop Controller

This block is the digital half of a pixel clock generator that follows the horizontal sync of an incoming video signal. A fast clock is divided by a fractional divisor, and each division produces a one-cycle pixel enable. For every line, the block counts the pixel enables between two rising edges of horizontal sync. It subtracts the wanted count, twelve times one plus the line-length setting, to get a signed phase error. A proportional-plus-integral law built from arithmetic shifts then moves the divisor.

Two pairs of shift gains are provided. The acquisition pair acts while the loop is hunting. The tracking pair acts once the loop is locked, which takes four lines in a row with a small error. A large error, a missing sync, or a new initial period setting puts the loop back into acquisition. A new initial period setting also reloads the divisor, so the loop starts close to the new line rate.

Top module: `line_pixel_pll`

## Requirements
- R1: During and after reset the divisor output equals the initial period setting in its integer part (8 bits) with a zero fraction (20 bits), and `locked` is low.
- R2: When the divisor fraction is zero, `pix_en` pulses exactly once every integer-divisor fast clocks. When the fraction is not zero, any 64 consecutive periods together last within one clock of 64 times the fractional divisor. Two pulses are never adjacent.
- R3: The target count is M = 12 × (line_len_cfg + 1). The error is the number of pixel enables in the clocks from one sync rising edge up to, but not including, the next, minus M. The first edge after reset, reload or timeout only starts a measurement and leaves the divisor unchanged.
- R4: On each evaluated line, the integral term first gains err·2^(B−19). The divisor then becomes that integral plus err·2^(A−11), in units of whole fast clocks.
- R5: (A, B) are the acquisition shifts while `locked` is low when the line is evaluated, and the tracking shifts while it is high.
- R6: `locked` rises at the evaluation of the fourth consecutive line whose error lies strictly between −24 and +24. An error of 23 keeps lock; an error of 24 does not count.
- R7: A line with an error outside the window clears the consecutive-line count, and `locked` falls on that same evaluation.
- R8: The integral term and the divisor saturate to the range [2.0, 256 − 2^−20]. They never wrap.
- R9: More than 2·M pixel enables without a sync edge clear `locked`. The next edge then only restarts measurement.
- R10: Changing the initial period setting loads it into both the divisor and the integral term on the next clock, clears lock and restarts measurement.
- R11: The divisor does not change on any cycle other than one that follows a line evaluation or a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active on its rising edge |
| line_len_cfg | input | 6 | Line-length setting; target count is 12 × (value + 1) |
| init_period_cfg | input | 8 | Initial divisor, in whole fast clocks |
| lock_prop_sh | input | 3 | Proportional shift A while locked |
| lock_integ_sh | input | 3 | Integral shift B while locked |
| acq_prop_sh | input | 3 | Proportional shift A while acquiring |
| acq_integ_sh | input | 3 | Integral shift B while acquiring |
| div_value | output | 28 | Divisor: 8 integer bits over 20 fractional bits |
| pix_en | output | 1 | One-cycle pixel clock enable |
| locked | output | 1 | Lock flag |

## Verification
The assertions guard the properties that hold on every cycle. Pixel enables are never adjacent. The divisor moves only after an evaluation or a reload, and a reload lands the exact setting. Lock rises only on an in-window evaluation and falls right after an out-of-window line or a sync timeout. The numerical side can only be shown by the directed scenarios, where the sync spacing is chosen so that the count per line is exact. These scenarios cover the divisor value after one update under each gain pair, the 23/24 window boundary, the four-line lock delay, both saturation limits, the average period produced by the fractional dither, and the restart behaviour after a missing sync.

// File: rtl/lpll_pkg.sv
package lpll_pkg;

  typedef enum logic {
    MODE_CAPTURE = 1'b0,
    MODE_LOCK    = 1'b1
  } loop_mode_e;

  typedef struct packed {
    logic [2:0] prop_sh;
    logic [2:0] integ_sh;
  } gain_pair_t;

endpackage

// File: rtl/lpll_sync_edge.sv
module lpll_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_evt
);

  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
  end

  assign rise_evt = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/lpll_frac_divider.sv
module lpll_frac_divider #(
  parameter int INT_W   = 8,
  parameter int FRAC    = 20,
  parameter int MIN_INT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INT_W+FRAC-1:0] div_value,
  output logic                  pix_en
);

  localparam int DW = INT_W + FRAC;

  logic [INT_W:0]  cyc_q;
  logic [INT_W:0]  len_q;
  logic [FRAC-1:0] facc_q;
  logic [FRAC:0]   fsum;

  assign fsum   = {1'b0, facc_q} + {1'b0, div_value[FRAC-1:0]};
  assign pix_en = (cyc_q >= len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      len_q  <= (INT_W+1)'(MIN_INT);
      facc_q <= '0;
    end else if (pix_en) begin
      cyc_q  <= '0;
      facc_q <= fsum[FRAC-1:0];
      len_q  <= {1'b0, div_value[DW-1:FRAC]} + {{INT_W{1'b0}}, fsum[FRAC]};
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  // R2: a period is never shorter than two clocks
  assert_pix_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en);

endmodule

// File: rtl/lpll_line_meter.sv
module lpll_line_meter #(
  parameter int LD_W = 6,
  parameter int CW   = 12,
  parameter int EW   = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 edge_evt,
  input  logic                 pix_en,
  input  logic                 restart,
  input  logic [LD_W-1:0]      ld_cfg,
  output logic                 line_done,
  output logic signed [EW-1:0] line_err,
  output logic                 timeout_evt
);

  function automatic logic [CW-1:0] target_count(input logic [LD_W-1:0] ld);
    return CW'(12 * (int'(ld) + 1));
  endfunction

  logic [CW-1:0] pix_cnt_q;
  logic          have_ref_q;
  logic [CW-1:0] m_cnt;
  logic [CW-1:0] lim_cnt;

  assign m_cnt       = target_count(ld_cfg);
  assign lim_cnt     = m_cnt << 1;
  assign line_done   = edge_evt & have_ref_q & ~restart;
  assign timeout_evt = pix_en & ~edge_evt & ~restart & (pix_cnt_q == lim_cnt);
  assign line_err    = $signed({1'b0, pix_cnt_q}) - $signed({1'b0, m_cnt});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt_q  <= '0;
      have_ref_q <= 1'b0;
    end else if (restart) begin
      pix_cnt_q  <= '0;
      have_ref_q <= 1'b0;
    end else if (edge_evt) begin
      pix_cnt_q  <= {{(CW-1){1'b0}}, pix_en};
      have_ref_q <= 1'b1;
    end else begin
      if (pix_en && pix_cnt_q <= lim_cnt) pix_cnt_q <= pix_cnt_q + 1'b1;
      if (timeout_evt) have_ref_q <= 1'b0;
    end
  end

  // R3: an evaluation needs a reference edge from an earlier cycle
  assert_ref_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> $past(edge_evt | have_ref_q));

endmodule

// File: rtl/lpll_lock_detect.sv
module lpll_lock_detect #(
  parameter int EW    = 13,
  parameter int WIN   = 24,
  parameter int LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_done,
  input  logic signed [EW-1:0] line_err,
  input  logic                 force_capture,
  output logic                 locked
);

  localparam int CNTW = $clog2(LINES + 1);

  logic [CNTW-1:0] good_q;
  logic            in_win;

  assign in_win = (line_err < EW'(WIN)) && (line_err > -EW'(WIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      locked <= 1'b0;
    end else if (force_capture) begin
      good_q <= '0;
      locked <= 1'b0;
    end else if (line_done) begin
      if (in_win) begin
        if (good_q != CNTW'(LINES)) good_q <= good_q + 1'b1;
        locked <= (good_q >= CNTW'(LINES - 1));
      end else begin
        good_q <= '0;
        locked <= 1'b0;
      end
    end
  end

  // R6: lock is only ever gained on an in-window evaluation
  assert_lock_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(line_done && in_win));

  // R7: an out-of-window line drops lock at once
  assert_lock_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !in_win) |=> !locked);

endmodule

// File: rtl/lpll_loop_filter.sv
module lpll_loop_filter
  import lpll_pkg::*;
#(
  parameter int INT_W   = 8,
  parameter int FRAC    = 20,
  parameter int EW      = 13,
  parameter int MIN_INT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic [INT_W-1:0]      pp_cfg,
  input  logic                  line_done,
  input  logic signed [EW-1:0]  line_err,
  input  gain_pair_t            gains,
  output logic [INT_W+FRAC-1:0] div_value
);

  localparam int     DW     = INT_W + FRAC;
  localparam int     AW     = DW + 6;
  localparam longint LO_L   = longint'(MIN_INT) <<< FRAC;
  localparam longint HI_L   = (longint'(1) <<< DW) - 1;
  localparam logic signed [AW-1:0] D_LO = AW'(LO_L);
  localparam logic signed [AW-1:0] D_HI = AW'(HI_L);

  function automatic logic signed [AW-1:0] sat(input logic signed [AW-1:0] v);
    if (v < D_LO) return D_LO;
    if (v > D_HI) return D_HI;
    return v;
  endfunction

  function automatic logic signed [AW-1:0] scaled(input logic signed [EW-1:0] e,
                                                  input int sh);
    logic signed [AW-1:0] w;
    w = AW'(e);
    return w <<< sh;
  endfunction

  function automatic logic signed [AW-1:0] from_pp(input logic [INT_W-1:0] p);
    logic signed [AW-1:0] w;
    w = AW'($signed({1'b0, p}));
    return sat(w <<< FRAC);
  endfunction

  logic signed [AW-1:0] integ_q;
  logic signed [AW-1:0] kp_term;
  logic signed [AW-1:0] ki_term;
  logic signed [AW-1:0] integ_next;
  logic signed [AW-1:0] div_next;

  assign kp_term    = scaled(line_err, FRAC - 11 + int'(gains.prop_sh));
  assign ki_term    = scaled(line_err, FRAC - 19 + int'(gains.integ_sh));
  assign integ_next = sat(integ_q + ki_term);
  assign div_next   = sat(integ_next + kp_term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q   <= from_pp(pp_cfg);
      div_value <= DW'(from_pp(pp_cfg));
    end else if (restart) begin
      integ_q   <= from_pp(pp_cfg);
      div_value <= DW'(from_pp(pp_cfg));
    end else if (line_done) begin
      integ_q   <= integ_next;
      div_value <= div_next[DW-1:0];
    end
  end

  // R10: a reload lands the new setting exactly
  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && pp_cfg >= INT_W'(MIN_INT)) |=>
      (div_value == {$past(pp_cfg), {FRAC{1'b0}}}));

  // R11: the divisor moves only after an evaluation or a reload
  assert_div_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_value) |-> $past(line_done || restart));

endmodule

// File: rtl/line_pixel_pll.sv
module line_pixel_pll
  import lpll_pkg::*;
#(
  parameter int INT_W       = 8,
  parameter int FRAC        = 20,
  parameter int LD_W        = 6,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_INT     = 2,
  parameter int LOCK_WIN    = 24,
  parameter int LOCK_LINES  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hsync_in,
  input  logic [LD_W-1:0]       line_len_cfg,
  input  logic [INT_W-1:0]      init_period_cfg,
  input  logic [2:0]            lock_prop_sh,
  input  logic [2:0]            lock_integ_sh,
  input  logic [2:0]            acq_prop_sh,
  input  logic [2:0]            acq_integ_sh,
  output logic [INT_W+FRAC-1:0] div_value,
  output logic                  pix_en,
  output logic                  locked
);

  localparam int CW = $clog2(2 * 12 * (1 << LD_W) + 2);
  localparam int EW = CW + 1;

  logic [INT_W-1:0]     pp_q;
  logic                 restart;
  logic                 edge_evt;
  logic                 line_done;
  logic                 timeout_evt;
  logic signed [EW-1:0] line_err;
  loop_mode_e           mode;
  gain_pair_t           gains;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pp_q <= init_period_cfg;
    else        pp_q <= init_period_cfg;
  end

  assign restart = (init_period_cfg != pp_q);
  assign mode    = locked ? MODE_LOCK : MODE_CAPTURE;
  assign gains   = (mode == MODE_LOCK) ? '{prop_sh: lock_prop_sh, integ_sh: lock_integ_sh}
                                       : '{prop_sh: acq_prop_sh,  integ_sh: acq_integ_sh};

  lpll_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hsync_in), .rise_evt(edge_evt)
  );

  lpll_frac_divider #(.INT_W(INT_W), .FRAC(FRAC), .MIN_INT(MIN_INT)) u_div (
    .clk(clk), .rst_n(rst_n), .div_value(div_value), .pix_en(pix_en)
  );

  lpll_line_meter #(.LD_W(LD_W), .CW(CW), .EW(EW)) u_meter (
    .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .pix_en(pix_en),
    .restart(restart), .ld_cfg(line_len_cfg), .line_done(line_done),
    .line_err(line_err), .timeout_evt(timeout_evt)
  );

  lpll_lock_detect #(.EW(EW), .WIN(LOCK_WIN), .LINES(LOCK_LINES)) u_lock (
    .clk(clk), .rst_n(rst_n), .line_done(line_done), .line_err(line_err),
    .force_capture(timeout_evt | restart), .locked(locked)
  );

  lpll_loop_filter #(.INT_W(INT_W), .FRAC(FRAC), .EW(EW), .MIN_INT(MIN_INT)) u_filt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pp_cfg(init_period_cfg),
    .line_done(line_done), .line_err(line_err), .gains(gains),
    .div_value(div_value)
  );

  // R9: a sync timeout forces acquisition mode
  assert_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !locked);

endmodule

// File: tb/test_line_pixel_pll.sv
module test_line_pixel_pll;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync_in = 1'b0;
  logic [5:0]  line_len_cfg = 6'd3;
  logic [7:0]  init_period_cfg = 8'd10;
  logic [2:0]  lock_prop_sh = 3'd2, lock_integ_sh = 3'd1;
  logic [2:0]  acq_prop_sh = 3'd5, acq_integ_sh = 3'd3;
  logic [27:0] div_value;
  logic        pix_en, locked;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  line_pixel_pll i_line_pixel_pll (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in),
    .line_len_cfg(line_len_cfg), .init_period_cfg(init_period_cfg),
    .lock_prop_sh(lock_prop_sh), .lock_integ_sh(lock_integ_sh),
    .acq_prop_sh(acq_prop_sh), .acq_integ_sh(acq_integ_sh),
    .div_value(div_value), .pix_en(pix_en), .locked(locked)
  );

  function automatic real dreal();
    return real'(div_value) / (2.0 ** 20);
  endfunction

  function automatic real expect_d(real base, int err, int a, int b);
    return base + err * (2.0 ** (a - 11)) + err * (2.0 ** (b - 19));
  endfunction

  task automatic chk_int(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_real(string req, string what, real act, real exp, real tol);
    total++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      bad++;
      $display("FAIL %s %s: actual=%f expected=%f", req, what, act, exp);
    end
  endtask

  task automatic run_line(int len);
    hsync_in = 1'b1;
    repeat (2) @(negedge clk);
    hsync_in = 1'b0;
    repeat (len - 2) @(negedge clk);
  endtask

  task automatic setup(int ld, int pp, int ap, int ai, int lp, int li);
    line_len_cfg = 6'(ld);
    lock_prop_sh = 3'(lp); lock_integ_sh = 3'(li);
    acq_prop_sh  = 3'(ap); acq_integ_sh  = 3'(ai);
    init_period_cfg = 8'(pp);
    repeat (600) @(negedge clk);
  endtask

  task automatic measure_periods(int n, output int clocks);
    int pulses = 0;
    clocks = 0;
    while (!pix_en) @(negedge clk);
    while (pulses < n) begin
      @(negedge clk);
      clocks++;
      if (pix_en) pulses++;
    end
  endtask

  task automatic t_reset();
    int clocks;
    chk_int("R1", "divisor after reset", div_value, 28'd10 << 20);
    chk_int("R1", "lock after reset", locked, 0);
    measure_periods(8, clocks);
    chk_int("R2", "8 integer periods", clocks, 80);
  endtask

  task automatic t_lock_window();
    setup(1, 12, 5, 3, 2, 1);                  // M = 24
    for (int i = 0; i < 4; i++) run_line(24 * 12);
    chk_int("R6", "no lock after 3 good lines", locked, 0);
    run_line(24 * 12);
    chk_int("R6", "lock after 4 good lines", locked, 1);
    chk_int("R3", "zero error leaves divisor", div_value, 28'd12 << 20);
    run_line((24 + 23) * 12);
    run_line(20);
    chk_int("R6", "error 23 keeps lock", locked, 1);
    chk_real("R5", "tracking gains used", dreal(), expect_d(12.0, 23, 2, 1), 1e-9);
  endtask

  task automatic t_timeout();
    longint dsave;
    setup(1, 10, 5, 3, 2, 1);
    for (int i = 0; i < 5; i++) run_line(24 * 10);
    chk_int("R9", "locked before gap", locked, 1);
    run_line(360);
    chk_int("R9", "lock held below 2M", locked, 1);
    repeat (240) @(negedge clk);
    chk_int("R9", "lock cleared after 2M", locked, 0);
    dsave = div_value;
    run_line(50);
    chk_int("R9", "edge after timeout no update", div_value, dsave);
  endtask

  task automatic t_out_window();
    setup(3, 11, 5, 3, 2, 1);                  // M = 48
    for (int i = 0; i < 5; i++) run_line(48 * 11);
    chk_int("R6", "locked at M=48", locked, 1);
    run_line((48 + 24) * 11);
    run_line(20);
    chk_int("R7", "error 24 drops lock", locked, 0);
    chk_real("R7", "update with tracking gains", dreal(), expect_d(11.0, 24, 2, 1), 1e-9);
    init_period_cfg = 8'd14;
    repeat (3) @(negedge clk);
    chk_int("R10", "reload divisor", div_value, 28'd14 << 20);
    chk_int("R10", "reload clears lock", locked, 0);
  endtask

  task automatic t_capture();
    int clocks;
    real d;
    setup(3, 20, 5, 3, 2, 1);
    run_line((48 + 5) * 20);
    chk_int("R3", "first edge only starts", div_value, 28'd20 << 20);
    run_line(20);
    d = expect_d(20.0, 5, 5, 3);
    chk_real("R4", "acquisition update +5", dreal(), d, 1e-9);
    measure_periods(64, clocks);
    chk_real("R2", "dithered 64 periods", real'(clocks), 64.0 * d, 1.0);
    setup(3, 30, 5, 3, 2, 1);
    run_line((48 - 7) * 30);
    run_line(20);
    chk_real("R4", "acquisition update -7", dreal(), expect_d(30.0, -7, 5, 3), 1e-9);
  endtask

  task automatic t_saturate();
    setup(3, 255, 7, 7, 2, 1);
    run_line((48 + 20) * 255);
    run_line(20);
    chk_int("R8", "upper clamp", div_value, 28'hFFF_FFFF);
    setup(3, 3, 7, 7, 2, 1);
    run_line((48 - 20) * 3);
    run_line(20);
    chk_int("R8", "lower clamp", div_value, 28'd2 << 20);
    chk_int("R8", "lock stays low", locked, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk_int("R1", "divisor in reset", div_value, 28'd10 << 20);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_lock_window();
    t_timeout();
    t_out_window();
    t_capture();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule